// File: doc/BRIEF.md
# Shift-Register Insertion Sorter

This block builds an ascending sorted set of small keys one key at a time. Each cycle it may take one new key. It compares the key against every stored slot at once. Every slot from the insertion point to the tail moves one place toward the tail, and the key goes into the slot that this frees. A full insertion therefore takes a single clock, whatever the position.

The sorted set is shown in parallel on a flat output bus, with slot 0 in the least significant bits. A count of the occupied slots and a full flag come with it. A clear input empties the set so that a new batch can start. Software or an upstream engine streams one batch of keys, reads the sorted bus once the count reaches the wanted size, and then clears.

Top module: `insertion_sorter`

## Requirements
- R1: The occupied slots, which are slot 0 up to slot count-1, always hold their keys in ascending order. Slot i sits in bits [i*KEY_W +: KEY_W] of `sorted_keys`.
- R2: A key that is larger than every stored key is written to slot `count`, and no stored key moves.
- R3: A key that is smaller than every stored key is written to slot 0, and every stored key moves up by one slot.
- R4: An accepted key shows on `sorted_keys` and `count` on the first rising edge after it is presented. When `in_valid` and `clear` are both low, the outputs stay unchanged.
- R5: `full` is high exactly when `count` equals DEPTH. While `full` is high, `in_valid` has no effect on `count` or `sorted_keys`.
- R6: When `clear` is high on a rising edge, `count` goes to 0 and `full` goes low. `clear` takes priority over `in_valid` in the same cycle, so the key offered with it is dropped.
- R7: After a synchronous active-low reset, `count` is 0, `full` is 0 and every slot of `sorted_keys` reads zero.
- R8: The extreme key values 0 and 2^KEY_W-1 sort correctly against each other and against mid-range keys.
- R9: Equal keys are all kept, one slot each, so duplicates add to `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Empties the sorted set |
| in_valid | input | 1 | A key is offered this cycle |
| in_key | input | KEY_W | Key to insert |
| count | output | $clog2(DEPTH+1) | Number of occupied slots |
| full | output | 1 | All DEPTH slots are occupied |
| sorted_keys | output | DEPTH*KEY_W | Sorted slots, slot 0 in the lowest bits |

## Verification
The bench fills the set in strictly descending order, so that every insertion lands at slot 0 and moves the whole chain. A design that shifted only some of the slots, or shifted in the wrong direction, would lose keys here. It fills the set in ascending order as well, which catches a design that disturbs stored keys when it appends at the tail. It feeds mixed keys that include duplicates, 0 and 255. A comparison with the wrong strictness or the wrong signedness would drop a duplicate or put an extreme key in the wrong place. It also offers keys while the set is full and together with `clear`. A design with a bad full guard would overflow or corrupt the tail slot, and one with the wrong priority would start the new batch with a stale key.

// File: rtl/isort_pkg.sv
// Package: shared operation encoding for the insertion sorter.
// Assumes: consumers size their own data paths from module parameters.
package isort_pkg;
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_INSERT = 2'd2
    } isort_op_e;
endpackage

// File: rtl/isort_cmp_slot.sv
// Module: one slot comparator. Flags that the new key belongs at or before
// this slot: the slot is empty, or its stored key is >= the new key.
// Assumes: unsigned keys; empty slots behave as larger than any key.
module isort_cmp_slot #(
    parameter int KEY_W = 8
) (
    input  logic [KEY_W-1:0] stored,
    input  logic             occupied,
    input  logic [KEY_W-1:0] key,
    output logic             at_or_before
);
    // Purpose: the empty-slot or greater-or-equal test for a single slot.
    always_comb begin
        at_or_before = !occupied || (stored >= key);
    end
endmodule

// File: rtl/isort_locate.sv
// Module: turns per-slot comparison flags into a one-hot write select (the
// first flagged slot) and a shift select (every slot after it).
// Assumes: flags may arrive in any pattern; the first set flag wins.
module isort_locate #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] at_or_before,
    output logic [DEPTH-1:0] take_new,
    output logic [DEPTH-1:0] take_prev
);
    // Purpose: a running OR finds the first flagged slot and marks the ones after it.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            take_new[i]  = at_or_before[i] && !seen;
            take_prev[i] = seen;
            seen         = seen || at_or_before[i];
        end
    end
endmodule

// File: rtl/isort_chain.sv
// Module: the key register chain with an occupied bit per slot. On insert a
// slot loads the new key, loads its lower neighbour's key, or holds.
// Assumes: take_new is one-hot or zero; take_prev[0] is zero.
module isort_chain
    import isort_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  isort_op_e              op,
    input  logic [KEY_W-1:0]       key,
    input  logic [DEPTH-1:0]       take_new,
    input  logic [DEPTH-1:0]       take_prev,
    output logic [DEPTH*KEY_W-1:0] keys_flat,
    output logic [DEPTH-1:0]       occ
);
    logic [KEY_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [KEY_W-1:0] lower_key;
        logic             lower_occ;

        if (i == 0) begin : g_head
            assign lower_key = '0;
            assign lower_occ = 1'b1;
        end else begin : g_body
            assign lower_key = slot_q[i-1];
            assign lower_occ = occ[i-1];
        end

        // Purpose: load a new key, take the lower neighbour's key, or hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (op == OP_INSERT) begin
                if (take_new[i]) begin
                    slot_q[i] <= key;
                end else if (take_prev[i]) begin
                    slot_q[i] <= lower_key;
                end
            end
        end

        // Purpose: the occupied region grows by one slot on insert and empties on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[i] <= 1'b0;
            end else if (op == OP_CLEAR) begin
                occ[i] <= 1'b0;
            end else if (op == OP_INSERT) begin
                occ[i] <= occ[i] || lower_occ;
            end
        end

        assign keys_flat[i*KEY_W +: KEY_W] = slot_q[i];
    end
endmodule

// File: rtl/insertion_sorter.sv
// Module: top of the single-cycle insertion sorter. Takes one key per cycle
// while not full and keeps up to DEPTH keys in ascending order.
// Assumes: clear outranks in_valid; keys held in slots at or above count are stale.
module insertion_sorter
    import isort_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   in_valid,
    input  logic [KEY_W-1:0]       in_key,
    output logic [CNT_W-1:0]       count,
    output logic                   full,
    output logic [DEPTH*KEY_W-1:0] sorted_keys
);
    isort_op_e        op;
    logic [DEPTH-1:0] at_or_before;
    logic [DEPTH-1:0] take_new;
    logic [DEPTH-1:0] take_prev;
    logic [DEPTH-1:0] occ;

    // Purpose: choose this cycle's operation; clear first, then a non-full insert.
    always_comb begin
        if (clear) begin
            op = OP_CLEAR;
        end else if (in_valid && !full) begin
            op = OP_INSERT;
        end else begin
            op = OP_HOLD;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        isort_cmp_slot #(.KEY_W(KEY_W)) u_cmp (
            .stored       (sorted_keys[i*KEY_W +: KEY_W]),
            .occupied     (occ[i]),
            .key          (in_key),
            .at_or_before (at_or_before[i])
        );
    end

    isort_locate #(.DEPTH(DEPTH)) u_locate (
        .at_or_before (at_or_before),
        .take_new     (take_new),
        .take_prev    (take_prev)
    );

    isort_chain #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .key       (in_key),
        .take_new  (take_new),
        .take_prev (take_prev),
        .keys_flat (sorted_keys),
        .occ       (occ)
    );

    // Purpose: count the occupied slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (op == OP_CLEAR) begin
            count <= '0;
        end else if (op == OP_INSERT) begin
            count <= count + 1'b1;
        end
    end

    assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/isort_chk.sv
// Module: assertion checker for insertion_sorter, attached with bind.
// Assumes: only ports of the sorter are observed.
module isort_chk #(
    parameter int KEY_W = 8,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clear,
    input logic                   in_valid,
    input logic [KEY_W-1:0]       in_key,
    input logic [CNT_W-1:0]       count,
    input logic                   full,
    input logic [DEPTH*KEY_W-1:0] sorted_keys
);
    for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_order
        a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(count) > i + 1) |->
            (sorted_keys[i*KEY_W +: KEY_W] <= sorted_keys[(i+1)*KEY_W +: KEY_W]));
    end

    a_r4_accept_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !full && !clear) |=> (count == $past(count) + 1'b1));

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clear) |=> ($stable(count) && $stable(sorted_keys)));

    a_r5_full_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (full && in_valid && !clear) |=> ($stable(count) && $stable(sorted_keys)));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && !full));
endmodule

bind insertion_sorter isort_chk #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_isort_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .in_valid    (in_valid),
    .in_key      (in_key),
    .count       (count),
    .full        (full),
    .sorted_keys (sorted_keys)
);

// File: tb/tb_insertion_sorter.sv
// Bench: scoreboard. The driver applies one operation per cycle, updates a
// reference sorted list and queues the expected outputs; the monitor pops
// one entry after each rising edge and compares it with the outputs.
module tb_insertion_sorter;
    localparam int KEY_W = 8;
    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   clear = 1'b0;
    logic                   in_valid = 1'b0;
    logic [KEY_W-1:0]       in_key = '0;
    logic [CNT_W-1:0]       count;
    logic                   full;
    logic [DEPTH*KEY_W-1:0] sorted_keys;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int                     cnt;
        bit                     fl;
        logic [DEPTH*KEY_W-1:0] keys;
        string                  tag;
    } exp_t;

    exp_t exp_q[$];
    int   model[$];

    insertion_sorter #(.KEY_W(KEY_W), .DEPTH(DEPTH)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .in_valid    (in_valid),
        .in_key      (in_key),
        .count       (count),
        .full        (full),
        .sorted_keys (sorted_keys)
    );

    always #5 clk = ~clk;

    // Driver: one cycle of stimulus plus the reference update and expectation.
    task automatic drive(input bit v, input bit c, input int k, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        clear    = c;
        in_key   = KEY_W'(k);
        if (c) begin
            model.delete();
        end else if (v && model.size() < DEPTH) begin
            int pos;
            pos = model.size();
            for (int j = model.size() - 1; j >= 0; j--) begin
                if (model[j] >= k) pos = j;
            end
            model.insert(pos, k);
        end
        e.cnt  = model.size();
        e.fl   = (model.size() == DEPTH);
        e.keys = '0;
        foreach (model[j]) e.keys[j*KEY_W +: KEY_W] = KEY_W'(model[j]);
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the queued expectation just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [DEPTH*KEY_W-1:0] got;
                e = exp_q.pop_front();
                got = '0;
                for (int j = 0; j < e.cnt; j++) got[j*KEY_W +: KEY_W] = sorted_keys[j*KEY_W +: KEY_W];
                checks++;
                if (int'(count) != e.cnt || full !== e.fl || got !== e.keys) begin
                    failures++;
                    $display("FAIL %s: count=%0d full=%0b keys=%h expected count=%0d full=%0b keys=%h",
                             e.tag, count, full, got, e.cnt, e.fl, e.keys);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state on the ports
        checks++;
        if (count !== '0 || full !== 1'b0 || sorted_keys !== '0) begin
            failures++;
            $display("FAIL R7: count=%0d full=%0b keys=%h expected 0 0 0", count, full, sorted_keys);
        end

        // R3: descending fill, each key lands at slot 0
        for (int k = 80; k > 0; k -= 10) drive(1'b1, 1'b0, k, "R3");
        // R5: full flag, then keys offered while full are ignored
        drive(1'b1, 1'b0, 5, "R5");
        drive(1'b1, 1'b0, 200, "R5");
        // R4: idle cycle holds the outputs
        drive(1'b0, 1'b0, 33, "R4");
        // R6: clear empties the set
        drive(1'b0, 1'b1, 0, "R6");

        // R2: ascending fill, appended at the tail
        for (int k = 1; k <= 6; k++) drive(1'b1, 1'b0, k * 7, "R2");
        drive(1'b0, 1'b0, 0, "R4");
        // R6: clear with a key offered in the same cycle
        drive(1'b1, 1'b1, 99, "R6");
        drive(1'b0, 1'b0, 0, "R6");

        // R8, R9, R1: extremes, duplicates and a mixed order
        drive(1'b1, 1'b0, 128, "R1");
        drive(1'b1, 1'b0, 255, "R8");
        drive(1'b1, 1'b0, 0, "R8");
        drive(1'b1, 1'b0, 128, "R9");
        drive(1'b1, 1'b0, 0, "R9");
        drive(1'b1, 1'b0, 255, "R9");
        drive(1'b1, 1'b0, 64, "R1");
        drive(1'b1, 1'b0, 129, "R1");
        drive(1'b1, 1'b0, 1, "R5");
        drive(1'b0, 1'b1, 0, "R6");
        drive(1'b1, 1'b0, 42, "R6");
        drive(1'b0, 1'b0, 0, "R4");

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule